// File: doc/BRIEF.md
# Background Scroll Offset Latch

This block holds the horizontal and vertical background scroll settings that a tile renderer uses. It decides when a value written by the CPU becomes visible to the renderer. The CPU can write at any time through a small register port. The display timing supplies a one-cycle strobe at the start of every scanline and another at the start of every frame. The renderer receives an X offset and a Y offset that change only at a line-start strobe and stay constant for the whole line.

The vertical offset does not come from adding the scroll value to the screen line. A running vertical counter is loaded from the vertical scroll register at frame start. A vertical scroll write reloads it at once, and it advances by one at every line start. At each line start the counter value is copied into the renderer's Y output, so a write in the middle of a line only affects the next line. The horizontal scroll value is buffered in its register and copied to the X output at the next line start.

A background-height mode sets the modulus at which the vertical counter wraps. Like other vertical geometry settings, it takes effect only at the next frame start.

Top module: `bg_scroll_latch`

## Requirements
- R1: After a synchronous reset, both fetch outputs are 0, both scroll registers are 0, the running vertical counter is 0 and the active height mode is 3 (tallest).
- R2: A write with `wr_sel` = 0 sets the horizontal scroll register. `fetch_x` takes that value at the next `line_start`. A write that lands in the same cycle as `line_start` appears one line later.
- R3: A write with `wr_sel` = 1 reloads the running vertical counter with the written value (masked to the active height) in that cycle. The next line shows the written value, not the old count plus one.
- R4: At each `line_start` with no vertical write, the running counter advances by one, modulo the active height.
- R5: `fetch_x` and `fetch_y` change only on a cycle that follows a `line_start`. Writes between line starts leave them unchanged.
- R6: When a vertical write and `line_start` fall in the same cycle, the counter takes the written value. `fetch_y` takes the count from before that write.
- R7: A `frame_start` loads the counter from the vertical scroll register, masked to the height mode that becomes active.
- R8: A write with `wr_sel` = 2 stores a pending height mode m = `wr_data[1:0]`. This selects a height of 2^(SCROLL_W-3+m) lines (128, 256, 512 or 1024 by default). It becomes active only at the next `frame_start`.
- R9: The counter and every value loaded into it wrap modulo the active height. For example, with height 128, a count of 127 advances to 0, and loading 300 yields 44.
- R10: When `frame_start` and `line_start` coincide, `fetch_y` takes the masked vertical register value and the counter becomes that value plus one. If a vertical write falls in the same cycle as `frame_start`, the write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 horizontal scroll, 1 vertical scroll, 2 height mode, 3 no target |
| wr_data | input | SCROLL_W | Write data |
| line_start | input | 1 | One-cycle strobe at the start of each scanline |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| fetch_x | output | SCROLL_W | Horizontal offset for the current line |
| fetch_y | output | SCROLL_W | Vertical offset for the current line |

## Verification
The vector walk first runs plain line sequences, which separate a running counter from a fixed offset. It then places writes between line starts, which separates per-line snapshotting from immediate visibility. Writes that coincide with a line start or a frame start expose the priority and the ordering between the snapshot and the reload. A mode change followed by loads and increments near 127 and 1023 shows whether the wrap uses the pending mode or the active one. A reset in the middle of a run confirms that every value returns to its reset state.

// File: rtl/bgscroll_pkg.sv
package bgscroll_pkg;
  typedef enum logic [1:0] {
    SEL_HSCROLL = 2'd0,
    SEL_VSCROLL = 2'd1,
    SEL_HMODE   = 2'd2,
    SEL_NONE    = 2'd3
  } scroll_sel_e;
endpackage

// File: rtl/scroll_regs.sv
module scroll_regs
  import bgscroll_pkg::*;
#(
  parameter int SCROLL_W = 10,
  parameter int MODE_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [SCROLL_W-1:0] wr_data,
  output logic [SCROLL_W-1:0] hreg,
  output logic [SCROLL_W-1:0] vreg,
  output logic [MODE_W-1:0]   mode_pend,
  output logic                vwrite
);
  logic hwrite, mwrite;

  always_comb begin
    hwrite = wr_en && (scroll_sel_e'(wr_sel) == SEL_HSCROLL);
    vwrite = wr_en && (scroll_sel_e'(wr_sel) == SEL_VSCROLL);
    mwrite = wr_en && (scroll_sel_e'(wr_sel) == SEL_HMODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hreg      <= '0;
      vreg      <= '0;
      mode_pend <= '1;
    end else begin
      if (hwrite) hreg <= wr_data;
      if (vwrite) vreg <= wr_data;
      if (mwrite) mode_pend <= wr_data[MODE_W-1:0];
    end
  end
endmodule

// File: rtl/vpos_counter.sv
module vpos_counter #(
  parameter int SCROLL_W = 10,
  parameter int MODE_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vwrite,
  input  logic [SCROLL_W-1:0] wr_data,
  input  logic                line_start,
  input  logic                frame_start,
  input  logic [SCROLL_W-1:0] vreg,
  input  logic [MODE_W-1:0]   mode_pend,
  output logic [SCROLL_W-1:0] line_y,
  output logic [SCROLL_W-1:0] vcnt
);
  localparam int NMODES    = 1 << MODE_W;
  localparam int BASE_LOG2 = SCROLL_W - NMODES + 1;

  logic [MODE_W-1:0]   mode_act;
  logic [MODE_W-1:0]   mode_eff;
  logic [SCROLL_W-1:0] mask_eff;
  logic [SCROLL_W-1:0] mask_act;
  logic [SCROLL_W-1:0] base;

  function automatic logic [SCROLL_W-1:0] height_mask(input logic [MODE_W-1:0] m);
    logic [SCROLL_W-1:0] r;
    for (int i = 0; i < SCROLL_W; i++) r[i] = (i < BASE_LOG2 + int'(m));
    return r;
  endfunction

  always_comb begin
    mode_eff = frame_start ? mode_pend : mode_act;
    mask_eff = height_mask(mode_eff);
    mask_act = height_mask(mode_act);
    base     = frame_start ? (vreg & mask_eff) : vcnt;
    line_y   = base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt     <= '0;
      mode_act <= '1;
    end else begin
      if (frame_start) mode_act <= mode_pend;
      if (vwrite)
        vcnt <= wr_data & mask_eff;
      else if (line_start)
        vcnt <= (base + SCROLL_W'(1)) & mask_eff;
      else if (frame_start)
        vcnt <= base;
    end
  end

  // R3
  vwrite_reload_chk: assert property (@(posedge clk) disable iff (rst)
    vwrite |=> vcnt == ($past(wr_data) & $past(mask_eff)));
  // R4
  line_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && !vwrite && !frame_start) |=> vcnt == (($past(vcnt) + SCROLL_W'(1)) & $past(mask_act)));
  // R7
  frame_load_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !vwrite && !line_start) |=> vcnt == ($past(vreg) & $past(mask_eff)));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(mode_act));
  // R9
  vcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (vcnt & ~mask_act) == '0);
endmodule

// File: rtl/line_snapshot.sv
module line_snapshot #(
  parameter int SCROLL_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_start,
  input  logic [SCROLL_W-1:0] hreg,
  input  logic [SCROLL_W-1:0] line_y,
  output logic [SCROLL_W-1:0] fetch_x,
  output logic [SCROLL_W-1:0] fetch_y
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_x <= '0;
      fetch_y <= '0;
    end else if (line_start) begin
      fetch_x <= hreg;
      fetch_y <= line_y;
    end
  end

  // R5
  hold_x_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(fetch_x));
  // R5
  hold_y_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(fetch_y));
endmodule

// File: rtl/bg_scroll_latch.sv
module bg_scroll_latch #(
  parameter int SCROLL_W = 10,
  parameter int MODE_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [SCROLL_W-1:0] wr_data,
  input  logic                line_start,
  input  logic                frame_start,
  output logic [SCROLL_W-1:0] fetch_x,
  output logic [SCROLL_W-1:0] fetch_y
);
  logic [SCROLL_W-1:0] hreg, vreg, line_y, vcnt;
  logic [MODE_W-1:0]   mode_pend;
  logic                vwrite;

  scroll_regs #(.SCROLL_W(SCROLL_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hreg(hreg), .vreg(vreg), .mode_pend(mode_pend), .vwrite(vwrite)
  );

  vpos_counter #(.SCROLL_W(SCROLL_W), .MODE_W(MODE_W)) u_vpos (
    .clk(clk), .rst(rst), .vwrite(vwrite), .wr_data(wr_data),
    .line_start(line_start), .frame_start(frame_start), .vreg(vreg),
    .mode_pend(mode_pend), .line_y(line_y), .vcnt(vcnt)
  );

  line_snapshot #(.SCROLL_W(SCROLL_W)) u_snap (
    .clk(clk), .rst(rst), .line_start(line_start), .hreg(hreg),
    .line_y(line_y), .fetch_x(fetch_x), .fetch_y(fetch_y)
  );

  // R6
  write_vs_snap_chk: assert property (@(posedge clk) disable iff (rst)
    (vwrite && line_start && !frame_start) |=> fetch_y == $past(vcnt));
endmodule

// File: tb/sim_bg_scroll_latch.sv
module sim_bg_scroll_latch;
  localparam int W = 10;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic line_start = 1'b0;
  logic frame_start = 1'b0;
  logic [W-1:0] fetch_x, fetch_y;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bg_scroll_latch #(.SCROLL_W(W), .MODE_W(2)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_start(line_start), .frame_start(frame_start),
    .fetch_x(fetch_x), .fetch_y(fetch_y)
  );

  // {req, wr_en, sel, data, line_start, frame_start, exp_x, exp_y}
  typedef logic [4+1+2+W+1+1+W+W-1:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {4'd2,  1'b1, 2'd0, 10'd5,   1'b0, 1'b0, 10'd0, 10'd0},    // R2 buffered X write
    {4'd3,  1'b1, 2'd1, 10'd100, 1'b0, 1'b0, 10'd0, 10'd0},    // R3 Y write not visible yet
    {4'd3,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd5, 10'd100},  // R3 reload visible
    {4'd4,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd5, 10'd101},  // R4 advance
    {4'd5,  1'b1, 2'd0, 10'd7,   1'b0, 1'b0, 10'd5, 10'd101},  // R5 mid-line X
    {4'd5,  1'b1, 2'd1, 10'd200, 1'b0, 1'b0, 10'd5, 10'd101},  // R5 mid-line Y
    {4'd3,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd7, 10'd200},  // R3 immediate reload
    {4'd6,  1'b1, 2'd1, 10'd50,  1'b1, 1'b0, 10'd7, 10'd201},  // R6 write with line
    {4'd6,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd7, 10'd50},   // R6 write won
    {4'd8,  1'b1, 2'd2, 10'd0,   1'b0, 1'b0, 10'd7, 10'd50},   // R8 mode pending
    {4'd8,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd7, 10'd51},   // R8 not active yet
    {4'd8,  1'b1, 2'd1, 10'd300, 1'b0, 1'b0, 10'd7, 10'd51},   // R8 load uses old mask
    {4'd7,  1'b0, 2'd0, 10'd0,   1'b0, 1'b1, 10'd7, 10'd51},   // R7 frame load
    {4'd9,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd7, 10'd44},   // R9 300 mod 128
    {4'd9,  1'b1, 2'd1, 10'd127, 1'b0, 1'b0, 10'd7, 10'd44},   // R9 load 127
    {4'd9,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd7, 10'd127},  // R9
    {4'd9,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd7, 10'd0},    // R9 wrap at 128
    {4'd10, 1'b0, 2'd0, 10'd0,   1'b1, 1'b1, 10'd7, 10'd127},  // R10 frame+line
    {4'd2,  1'b1, 2'd0, 10'd9,   1'b1, 1'b0, 10'd7, 10'd0},    // R2 X with line, R10 count+1
    {4'd2,  1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd9, 10'd1},    // R2 one line later
    {4'd8,  1'b1, 2'd2, 10'd3,   1'b0, 1'b0, 10'd9, 10'd1},    // R8 back to tallest
    {4'd10, 1'b1, 2'd1, 10'd600, 1'b0, 1'b1, 10'd9, 10'd1},    // R10 write beats frame
    {4'd10, 1'b0, 2'd0, 10'd0,   1'b1, 1'b0, 10'd9, 10'd600}   // R10 600 under new mode
  };

  task automatic check(input string tag, input logic [W-1:0] ex, input logic [W-1:0] ey);
    nchk++;
    if (fetch_x !== ex || fetch_y !== ey) begin
      nfail++;
      $display("FAIL %s: x=%0d y=%0d expected x=%0d y=%0d", tag, fetch_x, fetch_y, ex, ey);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [W-1:0] d,
                       input logic ls, input logic fs);
    wr_en = we; wr_sel = sel; wr_data = d; line_start = ls; frame_start = fs;
    @(negedge clk);
    wr_en = 1'b0; line_start = 1'b0; frame_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", '0, '0);
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      drive(v[2*W+2+W+2], v[2*W+2+W+1 -: 2], v[2*W+2+W-1 -: W], v[2*W+1], v[2*W]);
      tag = $sformatf("R%0d vec %0d", v[2*W+2+W+3 +: 4], i);
      check(tag, v[2*W-1 -: W], v[W-1:0]);
    end
    // R9 wrap at full height
    drive(1'b1, 2'd1, 10'd1023, 1'b0, 1'b0);
    drive(1'b0, 2'd0, '0, 1'b1, 1'b0);
    check("R9 load 1023", 10'd9, 10'd1023);
    drive(1'b0, 2'd0, '0, 1'b1, 1'b0);
    check("R9 wrap 1024", 10'd9, 10'd0);
    // R1 mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", '0, '0);
    drive(1'b0, 2'd0, '0, 1'b1, 1'b0);
    check("R4 count from reset", '0, 10'd0);
    drive(1'b0, 2'd0, '0, 1'b1, 1'b0);
    check("R4 second line", '0, 10'd1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule